// File: doc/BRIEF.md
# Event Edge Conditioner with Multi-Domain Stretch

This block conditions one event channel bit. A producer signal is sampled on the fast system clock and can leave the block in one of three ways. It can pass through as a level, one cycle late. It can be turned into a one-cycle pulse on rising edges, falling edges or both. It can also go straight to the output without any clocking, which is the asynchronous route.

Consumers of the channel may run on slower, divided clocks. Each of these destination domains supplies a one-cycle strobe on the fast clock, plus an enable bit that says whether the domain takes part. When stretch is on and an edge mode is selected, the block holds each detected edge high until every enabled domain has strobed at least once after the edge. This works even when the domains run at different rates, so every consumer sees the event.

Top module: `evt_edge_stretch`

## Requirements
- R1: While `rst_ni` is low and `async_i` is 0, `evt_o` is 0.
- R2: With `edge_sel_i` = 2'b00 (level) and `async_i` = 0, `evt_o` equals the value `sig_i` had at the preceding rising clock edge.
- R3: With `edge_sel_i` = 2'b01 (rising), stretch off and `async_i` = 0, a 0-to-1 change of `sig_i` seen at a clock edge gives `evt_o` = 1 for exactly the following cycle. Falling changes give no pulse.
- R4: With `edge_sel_i` = 2'b10 (falling), stretch off, a 1-to-0 change gives a one-cycle pulse on `evt_o`. Rising changes give none.
- R5: With `edge_sel_i` = 2'b11 (both), stretch off, every change of `sig_i` gives a one-cycle pulse.
- R6: When `async_i` = 1, `evt_o` equals `sig_i` combinationally. Edge select and stretch have no effect.
- R7: With stretch on and an edge mode selected, a qualifying edge raises `evt_o` in the next cycle. `evt_o` stays high until every domain with its `dom_en_i` bit set has raised its `dom_stb_i` bit in some cycle after the edge cycle. It drops in the cycle after the last of those strobes.
- R8: Strobes from domains whose enable bit is 0 are ignored. With no domain enabled, a stretched edge gives a one-cycle pulse.
- R9: A qualifying edge that arrives while a stretch is in progress discards the strobes collected so far and restarts the hold. `evt_o` stays high.
- R10: A strobe in the same cycle as the triggering edge is not counted toward releasing the hold.
- R11: Reset clears the previous-sample register to 0. If `sig_i` is high when reset is released in rising mode, the first clock edge produces a pulse.
- R12: In level mode, `stretch_en_i` has no effect and the level passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Producer signal |
| edge_sel_i | input | 2 | 00 level, 01 rising, 10 falling, 11 both |
| async_i | input | 1 | Forward `sig_i` unclocked; edge and stretch disabled |
| stretch_en_i | input | 1 | Hold edge pulses until enabled domains have strobed |
| dom_en_i | input | N_DOM | Per-domain participation enable |
| dom_stb_i | input | N_DOM | Per-domain one-cycle sample strobe |
| evt_o | output | 1 | Conditioned event channel bit |

## Verification
Two kinds of internal fault show up at the port. A stale previous-sample register shows as a pulse that is missing or comes one cycle late, and this is visible in the very first cycle after the input changes. A corrupted per-domain seen flag shows as a stretched pulse that ends one or more strobes too early or too late. The retrigger and same-cycle-strobe cases are built so that keeping old flags moves the falling edge of `evt_o` by at least one strobe. Domain-enable faults appear when a disabled domain's strobe ends the hold, or when a hold with no domains enabled lasts longer than one cycle.

// File: rtl/evt_cond_pkg.sv
package evt_cond_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_cond_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise = sig_i & ~prev_q;
  assign fall = ~sig_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_stretch.sv
module evt_stretch #(
  parameter int unsigned N_DOM = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic [N_DOM-1:0] dom_en_i,
  input  logic [N_DOM-1:0] dom_stb_i,
  output logic             hold_o
);
  logic             busy_q, busy_d;
  logic [N_DOM-1:0] seen_q, seen_upd, covered;
  logic             complete;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign seen_upd[d] = seen_q[d] | (dom_stb_i[d] & dom_en_i[d]);
    assign covered[d]  = seen_upd[d] | ~dom_en_i[d];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              seen_q[d] <= 1'b0;
      else if (!run_i || trig_i) seen_q[d] <= 1'b0;  // restart on new edge
      else if (busy_q)          seen_q[d] <= seen_upd[d];
      else                      seen_q[d] <= 1'b0;
    end
  end

  assign complete = &covered;

  always_comb begin
    if (!run_i)      busy_d = 1'b0;
    else if (trig_i) busy_d = 1'b1;
    else             busy_d = busy_q & ~complete;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign hold_o = busy_q;
endmodule

// File: rtl/evt_out_stage.sv
module evt_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic edge_mode_i,
  input  logic stretch_mode_i,
  input  logic sig_i,
  input  logic hit_i,
  input  logic hold_i,
  output logic evt_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= edge_mode_i ? hit_i : sig_i;
  end

  always_comb begin
    if (async_i)             evt_o = sig_i;
    else if (stretch_mode_i) evt_o = hold_i;
    else                     evt_o = out_q;
  end
endmodule

// File: rtl/evt_edge_stretch.sv
module evt_edge_stretch
  import evt_cond_pkg::*;
#(
  parameter int unsigned N_DOM = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             async_i,
  input  logic             stretch_en_i,
  input  logic [N_DOM-1:0] dom_en_i,
  input  logic [N_DOM-1:0] dom_stb_i,
  output logic             evt_o
);
  edge_sel_e sel;
  logic      hit, edge_mode, run, hold;

  assign sel       = edge_sel_e'(edge_sel_i);
  assign edge_mode = (sel != EDGE_OFF);
  assign run       = ~async_i & edge_mode & stretch_en_i;

  evt_edge_det u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .sel_i  (sel),
    .hit_o  (hit)
  );

  evt_stretch #(.N_DOM(N_DOM)) u_str (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .trig_i    (run & hit),
    .dom_en_i  (dom_en_i),
    .dom_stb_i (dom_stb_i),
    .hold_o    (hold)
  );

  evt_out_stage u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .async_i        (async_i),
    .edge_mode_i    (edge_mode),
    .stretch_mode_i (edge_mode & stretch_en_i),
    .sig_i          (sig_i),
    .hit_i          (hit),
    .hold_i         (hold),
    .evt_o          (evt_o)
  );
endmodule

// File: rtl/evt_edge_stretch_chk.sv
module evt_edge_stretch_chk #(
  parameter int unsigned N_DOM = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sig_i,
  input logic [1:0]       edge_sel_i,
  input logic             async_i,
  input logic             stretch_en_i,
  input logic [N_DOM-1:0] dom_en_i,
  input logic [N_DOM-1:0] dom_stb_i,
  input logic             evt_o
);
  logic prev_c;
  logic run_c, edge_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_c <= 1'b0;
    else         prev_c <= sig_i;
  end

  assign run_c  = !async_i && stretch_en_i && (edge_sel_i != 2'b00);
  assign edge_c = (edge_sel_i[0] && sig_i && !prev_c) || (edge_sel_i[1] && !sig_i && prev_c);

  AST_ASYNC_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_i |-> (evt_o == sig_i)); // R6

  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_i && edge_sel_i == 2'b00) |=>
      (async_i || edge_sel_i != 2'b00 || evt_o == $past(sig_i))); // R2

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_i && edge_sel_i == 2'b01 && !stretch_en_i && sig_i && !prev_c) |=>
      (async_i || stretch_en_i || evt_o)); // R3

  AST_FALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_i && edge_sel_i == 2'b10 && !stretch_en_i && !sig_i && prev_c) |=>
      (async_i || stretch_en_i || evt_o)); // R4

  AST_HOLD_UNTIL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_c && evt_o && (|dom_en_i) && !(|(dom_stb_i & dom_en_i)) && $stable(dom_en_i)) |=>
      (!run_c || evt_o)); // R7

  AST_NO_DOM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_c && evt_o && dom_en_i == '0 && !edge_c) |=> (!run_c || !evt_o)); // R8
endmodule

bind evt_edge_stretch evt_edge_stretch_chk #(.N_DOM(N_DOM)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sig_i        (sig_i),
  .edge_sel_i   (edge_sel_i),
  .async_i      (async_i),
  .stretch_en_i (stretch_en_i),
  .dom_en_i     (dom_en_i),
  .dom_stb_i    (dom_stb_i),
  .evt_o        (evt_o)
);

// File: tb/sim_evt_edge_stretch.sv
`timescale 1ns/1ps
module sim_evt_edge_stretch;
  localparam int unsigned N_DOM = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sig_i = 1'b0;
  logic [1:0]       edge_sel_i = 2'b00;
  logic             async_i = 1'b0;
  logic             stretch_en_i = 1'b0;
  logic [N_DOM-1:0] dom_en_i = '0;
  logic [N_DOM-1:0] dom_stb_i = '0;
  logic             evt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  evt_edge_stretch #(.N_DOM(N_DOM)) u0 (.*);

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (evt_o !== exp) begin
      n_bad++;
      $display("FAIL %s: evt_o=%b expected %b at %0t", tag, evt_o, exp, $time);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic str, input logic [N_DOM-1:0] en);
    edge_sel_i = sel; stretch_en_i = str; dom_en_i = en; async_i = 1'b0; dom_stb_i = '0;
  endtask

  task automatic t_reset();
    sig_i = 1'b1; cfg(2'b00, 1'b0, '0); rst_ni = 1'b0;
    step(); step();
    chk(1'b0, "R1 reset low");
    // R11: release with sig high in rising mode
    edge_sel_i = 2'b01;
    rst_ni = 1'b1;
    step(); chk(1'b1, "R11 pulse after reset");
    step(); chk(1'b0, "R11 pulse ends");
  endtask

  task automatic t_level();
    cfg(2'b00, 1'b0, '0);
    sig_i = 1'b0; step(); chk(1'b0, "R2 low");
    sig_i = 1'b1; step(); chk(1'b1, "R2 high");
    step(); chk(1'b1, "R2 held");
    sig_i = 1'b0; step(); chk(1'b0, "R2 back low");
  endtask

  task automatic t_rise();
    cfg(2'b01, 1'b0, '0);
    sig_i = 1'b0; step();
    sig_i = 1'b1; step(); chk(1'b1, "R3 pulse");
    step(); chk(1'b0, "R3 one cycle");
    sig_i = 1'b0; step(); chk(1'b0, "R3 fall ignored");
  endtask

  task automatic t_fall();
    cfg(2'b10, 1'b0, '0);
    sig_i = 1'b1; step(); chk(1'b0, "R4 rise ignored");
    sig_i = 1'b0; step(); chk(1'b1, "R4 pulse");
    step(); chk(1'b0, "R4 one cycle");
  endtask

  task automatic t_both();
    cfg(2'b11, 1'b0, '0);
    sig_i = 1'b1; step(); chk(1'b1, "R5 rise pulse");
    step(); chk(1'b0, "R5 rise ends");
    sig_i = 1'b0; step(); chk(1'b1, "R5 fall pulse");
    step(); chk(1'b0, "R5 fall ends");
  endtask

  task automatic t_async();
    cfg(2'b01, 1'b1, '1);
    async_i = 1'b1;
    sig_i = 1'b1; #1; chk(1'b1, "R6 forward high");
    step(); chk(1'b1, "R6 no pulse shape");
    sig_i = 1'b0; #1; chk(1'b0, "R6 forward low");
    step();
    async_i = 1'b0; step(); chk(1'b0, "R6 exit quiet");
  endtask

  task automatic t_stretch();
    cfg(2'b01, 1'b1, 3'b111);
    sig_i = 1'b0; step();
    sig_i = 1'b1; dom_stb_i = 3'b001; step(); chk(1'b1, "R7 raise");
    dom_stb_i = 3'b010; step(); chk(1'b1, "R7 hold");
    dom_stb_i = 3'b100; step(); chk(1'b1, "R10 edge-cycle strobe not counted");
    dom_stb_i = 3'b001; step(); chk(1'b0, "R7 release after last");
    dom_stb_i = '0; sig_i = 1'b0; step(); chk(1'b0, "R7 fall not selected");
  endtask

  task automatic t_retrigger();
    cfg(2'b11, 1'b1, 3'b111);
    sig_i = 1'b1; step(); chk(1'b1, "R9 first edge");
    dom_stb_i = 3'b011; step(); chk(1'b1, "R9 partial");
    sig_i = 1'b0; dom_stb_i = 3'b100; step(); chk(1'b1, "R9 retrigger holds");
    dom_stb_i = 3'b100; step(); chk(1'b1, "R9 old strobes discarded");
    dom_stb_i = 3'b011; step(); chk(1'b0, "R9 release");
    dom_stb_i = '0;
  endtask

  task automatic t_disabled();
    cfg(2'b01, 1'b1, 3'b010);
    sig_i = 1'b0; step();
    sig_i = 1'b1; step(); chk(1'b1, "R8 raise");
    dom_stb_i = 3'b101; step(); chk(1'b1, "R8 disabled strobes ignored");
    dom_stb_i = 3'b010; step(); chk(1'b0, "R8 enabled strobe releases");
    dom_stb_i = '0; dom_en_i = '0;
    sig_i = 1'b0; step();
    sig_i = 1'b1; step(); chk(1'b1, "R8 none enabled raise");
    step(); chk(1'b0, "R8 none enabled one cycle");
  endtask

  task automatic t_level_stretch();
    cfg(2'b00, 1'b1, 3'b111);
    sig_i = 1'b0; step(); chk(1'b0, "R12 low");
    sig_i = 1'b1; step(); chk(1'b1, "R12 high");
    step(); chk(1'b1, "R12 level held");
    sig_i = 1'b0; step(); chk(1'b0, "R12 low again");
  endtask

  initial begin
    step();
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_async();
    t_stretch();
    t_retrigger();
    t_disabled();
    t_level_stretch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule